// File: doc/BRIEF.md
# Push-Key Press Confirmer and Output Toggler

This block watches an active-low push key and flips a single output bit (typically an LED) once for every confirmed press. A press shows up as a falling edge on the key after a multi-flop synchroniser. Each such edge is recorded as a pending event. The block then takes the events one at a time. For each one it waits a fixed settling interval, re-reads the synchronised key level once, and toggles the output only if the key is still held low. If the key has already gone back high, the event is discarded as a short glitch.

The settling interval is set by two parameters: the clock frequency and a delay in microseconds. The defaults give 50 MHz and 5 ms, which is 250000 cycles. Falling edges that arrive while an event is being settled are not lost. A small saturating counter holds them, and they are served back to back once the current event finishes.

Top module: `key_toggle_debounce`

## Requirements
- R1: While reset is asserted, and after it is released with no key activity, `led_on` is 0.
- R2: Each falling edge of the synchronised key adds one pending event. A rising edge (key release) adds none and leaves `led_on` unchanged.
- R3: An event is taken in the idle state. The block then waits exactly DELAY_CYC = (CLK_HZ/1000000)*SETTLE_US cycles and samples the key on the cycle after that. A key held low from a port change just before clock edge 1 toggles `led_on` at edge 5+DELAY_CYC and not earlier.
- R4: If the sampled key level is high (1), the event is dropped and `led_on` keeps its value.
- R5: A sample that finds the key low (0) inverts `led_on` exactly once.
- R6: Pending events are served one after another. Each event gets its own full settling wait, and taking an event lowers the pending count by one.
- R7: The pending count saturates at 2**CNT_W-1. Further edges at that count are dropped rather than wrapping the count to zero.
- R8: The key passes through SYNC_STAGES flip-flops, reset to the released level 1, before both edge detection and sampling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_n | input | 1 | Raw push key, low while pressed |
| led_on | output | 1 | Toggled output, 0 after reset |

## Verification
On every cycle, the checker confirms four things:
- the output only changes on the cycle after a sample that saw the key low;
- a sample that saw the key high never changes the output;
- every stay in the waiting state lasts exactly DELAY_CYC cycles;
- the pending count rises on each edge, falls by one when an event is taken, and never wraps past its maximum.

Only the bench scenarios can show the overall effect of a burst of bounces. Those scenarios cover the exact number of toggles once saturation has dropped events, the absolute latency from the key pin through the synchroniser, and the fact that release edges and short glitches leave the output alone.

// File: rtl/kdt_pkg.sv
`timescale 1ns/1ps
package kdt_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_WAIT   = 2'd1,
      ST_SAMPLE = 2'd2
   } kdt_state_e;
endpackage

// File: rtl/kdt_key_sync.sv
`timescale 1ns/1ps
module kdt_key_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic key_n,
   output logic key_lvl,
   output logic key_fall
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b1;
            else        chain_q[0] <= key_n;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b1;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign key_lvl  = chain_q[STAGES-1];
   assign key_fall = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/kdt_pend_counter.sv
`timescale 1ns/1ps
module kdt_pend_counter #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         dec,
   output logic [W-1:0] cnt,
   output logic         nonzero
);
   localparam logic [W-1:0] MAXV = {W{1'b1}};
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (inc && !dec) begin
         if (cnt_q != MAXV) cnt_q <= cnt_q + 1'b1;
      end else if (dec && !inc) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign cnt     = cnt_q;
   assign nonzero = (cnt_q != '0);
endmodule

// File: rtl/kdt_settle_timer.sv
`timescale 1ns/1ps
module kdt_settle_timer #(
   parameter int CYC = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int TW = (CYC < 2) ? 1 : $clog2(CYC);
   localparam logic [TW-1:0] LAST = TW'(CYC - 1);
   logic [TW-1:0] tmr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tmr_q <= '0;
      else if (!run)    tmr_q <= '0;
      else if (!done)   tmr_q <= tmr_q + 1'b1;
   end

   assign done = run && (tmr_q == LAST);
endmodule

// File: rtl/key_toggle_debounce.sv
`timescale 1ns/1ps
module key_toggle_debounce #(
   parameter int CLK_HZ      = 50_000_000,
   parameter int SETTLE_US   = 5000,
   parameter int CNT_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic key_n,
   output logic led_on
);
   import kdt_pkg::*;

   localparam int CYC_PER_US = CLK_HZ / 1_000_000;
   localparam int DELAY_CYC  = CYC_PER_US * SETTLE_US;

   if (CYC_PER_US < 1) begin : g_bad_clk
      $error("CLK_HZ must be at least 1 MHz");
   end
   if (SETTLE_US < 1) begin : g_bad_delay
      $error("SETTLE_US must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic             key_lvl;
   logic             key_fall;
   logic [CNT_W-1:0] pend_cnt;
   logic             pend_nz;
   logic             take;
   logic             tmr_done;
   kdt_state_e       state_q;
   logic             led_q;

   kdt_key_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_n    (key_n),
      .key_lvl  (key_lvl),
      .key_fall (key_fall)
   );

   assign take = (state_q == ST_IDLE) && pend_nz;

   kdt_pend_counter #(.W(CNT_W)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (key_fall),
      .dec     (take),
      .cnt     (pend_cnt),
      .nonzero (pend_nz)
   );

   kdt_settle_timer #(.CYC(DELAY_CYC)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state_q == ST_WAIT),
      .done  (tmr_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         led_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE:   if (take) state_q <= ST_WAIT;
            ST_WAIT:   if (tmr_done) state_q <= ST_SAMPLE;
            ST_SAMPLE: begin
               if (!key_lvl) led_q <= ~led_q;
               state_q <= ST_IDLE;
            end
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

   assign led_on = led_q;
endmodule

// File: rtl/kdt_checker.sv
`timescale 1ns/1ps
module kdt_checker #(
   parameter int DELAY_CYC = 250000,
   parameter int CNT_W     = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               led_on,
   input kdt_pkg::kdt_state_e state,
   input logic [CNT_W-1:0]   pend,
   input logic               key_lvl,
   input logic               key_fall
);
   import kdt_pkg::*;
   localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

   logic [31:0] wait_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                wait_len <= '0;
      else if (state == ST_WAIT) wait_len <= wait_len + 1;
      else if (state == ST_IDLE) wait_len <= '0;
   end

   // R5: output only moves after a low sample
   a_r5_led_from_sample: assert property (@(posedge clk) disable iff (!rst_n)
      (led_on != $past(led_on)) |-> ($past(state) == ST_SAMPLE && !$past(key_lvl)));

   // R4: high sample leaves the output alone
   a_r4_glitch_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SAMPLE && key_lvl) |=> $stable(led_on));

   // R3: wait lasts DELAY_CYC cycles
   a_r3_wait_length: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SAMPLE) |-> (wait_len == DELAY_CYC));

   // R6: taking an event lowers the count by one
   a_r6_take_decrements: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && pend != '0 && !key_fall) |=>
      (state == ST_WAIT && pend == $past(pend) - 1'b1));

   // R2: edge while busy raises the count
   a_r2_edge_counts: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && key_fall && pend != MAXV) |=> (pend == $past(pend) + 1'b1));

   // R7: no wrap at the maximum
   a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && key_fall && pend == MAXV) |=> (pend == MAXV));
endmodule

bind key_toggle_debounce kdt_checker #(.DELAY_CYC(DELAY_CYC), .CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .led_on   (led_on),
   .state    (state_q),
   .pend     (pend_cnt),
   .key_lvl  (key_lvl),
   .key_fall (key_fall)
);

// File: tb/key_toggle_debounce_test.sv
`timescale 1ns/1ps
module key_toggle_debounce_test;
   localparam int D     = 40;   // 1 MHz nominal x 40 us
   localparam int CW    = 2;
   localparam int PMAX  = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic key_n = 1'b1;
   logic led_on;
   int   checks = 0;
   int   errors = 0;
   logic exp_led = 1'b0;
   bit   done = 0;

   always #4 clk = ~clk;

   key_toggle_debounce #(
      .CLK_HZ(1_000_000), .SETTLE_US(D), .CNT_W(CW), .SYNC_STAGES(2)
   ) uut (
      .clk(clk), .rst_n(rst_n), .key_n(key_n), .led_on(led_on)
   );

   task automatic chk(input logic act, input logic exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: led_on=%0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // events served for a burst of n falling edges that all land in the first wait
   function automatic int served(input int n);
      return 1 + (((n - 1) < PMAX) ? (n - 1) : PMAX);
   endfunction

   task automatic burst(input int n, input bit end_low, input bit rnd, input string req);
      int ev;
      for (int k = 0; k < n; k++) begin
         key_n = 1'b0;
         cyc(rnd ? 2 + ($urandom % 2) : 3);
         if (k != n - 1 || !end_low) begin
            key_n = 1'b1;
            cyc(rnd ? 2 + ($urandom % 2) : 3);
         end
      end
      ev = end_low ? served(n) : 0;
      cyc(served(n) * (D + 4) + 20);
      if (ev % 2 == 1) exp_led = ~exp_led;
      chk(led_on, exp_led, req);
      key_n = 1'b1;
      cyc(D + 10);
      chk(led_on, exp_led, "R2 release");
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      cyc(1);
      chk(led_on, 1'b0, "R1 in reset");
      rst_n = 1'b1;
      cyc(5);
      chk(led_on, 1'b0, "R1 after reset");

      // R3/R8 exact latency, R5 single toggle
      key_n = 1'b0;
      cyc(4 + D);
      chk(led_on, 1'b0, "R3 no early toggle");
      cyc(1);
      exp_led = 1'b1;
      chk(led_on, 1'b1, "R3 R5 toggle on time");
      cyc(D + 10);
      chk(led_on, 1'b1, "R5 one toggle only");
      key_n = 1'b1;
      cyc(3 * D);
      chk(led_on, 1'b1, "R2 release ignored");

      // R4 glitch
      key_n = 1'b0;
      cyc(3);
      key_n = 1'b1;
      cyc(2 * D + 10);
      chk(led_on, exp_led, "R4 glitch dropped");

      // R6 two events held low: two toggles
      burst(2, 1'b1, 1'b0, "R6 two events");
      // R6 three events: odd parity
      burst(3, 1'b1, 1'b0, "R6 three events");
      // R7 saturation: 5 edges -> 4 served
      burst(5, 1'b1, 1'b0, "R7 saturation");
      // R4 bounce ending high
      burst(4, 1'b0, 1'b0, "R4 bounce release");

      for (int i = 0; i < 12; i++) begin
         burst(1 + ($urandom % 5), bit'($urandom % 2), 1'b1, "R6 R7 random burst");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule